// File: doc/BRIEF.md
# Flash Suspend/Resume Sequencer

This block is the command-side controller of a NOR-flash style write state machine. It accepts decoded bus commands with a target block number: word program, block erase, suspend, resume, clear status, read array and read status. It tracks one erase and one program operation. Either can be running, suspended or absent, and a program may be nested inside a suspended erase. The embedded operations are plain down-counters with fixed lengths, so the remaining work of a suspended erase and of a suspended program is held in separate registers.

The host sees a busy flag, a suspended flag, an 8-bit status byte, the current read mode and a combinational flag. That flag says whether an array read of the block on `rd_blk` would be served. While something is suspended, the host switches back to array mode and reads blocks that are not tied up by the suspended work. It then resumes with the resume command, which may be sent with any block number.

Top module: `flash_susp_seq`

## Requirements
- R1: `rd_allow` is 1 only when the read mode is array, no operation is running, and `rd_blk` is neither the block of a suspended erase nor the block of a suspended program. Other blocks stay readable while work is suspended.
- R2: An erase command (code 2) is rejected whenever an erase or a program exists, whether running or suspended, including while a program is suspended. A rejection sets status bit 5, and the erase does not start.
- R3: A program command (code 1) is accepted when nothing is running and no program exists, including while an erase is suspended, unless it targets the suspended erase's block. A rejection sets status bit 4. An accepted program nested in an erase can itself be suspended.
- R4: Status bit 7 is 1 when nothing is running, bit 6 is 1 while the erase is suspended and bit 2 is 1 while the program is suspended. In the nested condition bits 7, 6 and 2 all read 1, and the unused bits 3, 1 and 0 read 0.
- R5: A resume command (code 4) is accepted with any block number and always switches the read mode to status (`read_mode` = 1).
- R6: A program runs for PRG_CYC clock cycles and an erase for ERS_CYC clock cycles of running time. A suspend (code 3) freezes the remaining count. Resume continues from that count, raises busy again and clears the matching suspend bit.
- R7: With both operations suspended, the first resume restarts only the program, and the erase stays suspended. A resume given while that program runs has no effect on the erase. A second resume after the program finishes restarts the erase.
- R8: A suspend command given while nothing is running is ignored, so the busy, suspended and status outputs do not change.
- R9: Status bits 5 and 4 stay set until a clear-status command (code 5) clears both.
- R10: After reset the block is idle, status is 0x80 and the read mode is array (`read_mode` = 0). Read array (code 6) selects array mode and read status (code 7) selects status mode. An accepted program, erase or suspend selects status mode. Rejected commands, clear status and ignored suspends leave the mode unchanged. Code 0 is no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 3 | Command code, see R2, R3, R5, R6, R9, R10 |
| cmd_blk | input | BLK_W | Target block of the command |
| rd_blk | input | BLK_W | Block an array read would address |
| busy | output | 1 | A program or erase is counting down |
| suspended | output | 1 | At least one operation is suspended |
| status | output | 8 | Status byte, bit layout per R4 and R2/R3 |
| read_mode | output | 1 | 0 = array, 1 = status |
| rd_allow | output | 1 | Array read of `rd_blk` would be served |

## Verification
The assertions assume that at most one command arrives per cycle, that `cmd_code` is stable across the clock edge and that the block numbers are within BLK_W bits. They also assume that a suspend is never sent in the final counting cycle of an operation, since in that cycle the suspend wins over completion by design. The stimulus drives every command and block number half a cycle ahead of the edge, holds them for a full cycle, and places suspends only at points where several cycles of work remain. Reads are probed through `rd_blk` with the same timing, so the combinational permission is sampled after the state it depends on has settled.

// File: rtl/fss_pkg.sv
package fss_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_PROG     = 3'd1,
    CMD_ERASE    = 3'd2,
    CMD_SUSP     = 3'd3,
    CMD_RESUME   = 3'd4,
    CMD_CLR      = 3'd5,
    CMD_RD_ARRAY = 3'd6,
    CMD_RD_STAT  = 3'd7
  } cmd_e;

  localparam int SR_READY = 7;
  localparam int SR_ESUSP = 6;
  localparam int SR_EERR  = 5;
  localparam int SR_PERR  = 4;
  localparam int SR_PSUSP = 2;

  localparam int OP_PRG = 0;
  localparam int OP_ERS = 1;
  localparam int N_OPS  = 2;

  function automatic logic [7:0] pack_status(input logic ready, input logic esusp,
                                             input logic eerr, input logic perr,
                                             input logic psusp);
    logic [7:0] s;
    s           = 8'h00;
    s[SR_READY] = ready;
    s[SR_ESUSP] = esusp;
    s[SR_EERR]  = eerr;
    s[SR_PERR]  = perr;
    s[SR_PSUSP] = psusp;
    return s;
  endfunction

  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/fss_op_timer.sv
module fss_op_timer #(
  parameter int CW  = 5,
  parameter int DUR = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  output logic [CW-1:0] rem,
  output logic          done
);

  assign done = run && (rem == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     rem <= '0;
    else if (start) rem <= CW'(DUR);
    else if (run)   rem <= rem - CW'(1);
  end

  AST_TIMER_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem != '0));  // R6

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(rem));  // R6

endmodule

// File: rtl/fss_cmd_check.sv
module fss_cmd_check
  import fss_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             cmd_valid,
  input  cmd_e             cmd,
  input  logic [BLK_W-1:0] blk,
  input  logic             ers_act,
  input  logic             ers_susp,
  input  logic             prg_act,
  input  logic             prg_susp,
  input  logic [BLK_W-1:0] ers_blk,
  output logic             acc_prog,
  output logic             rej_prog,
  output logic             acc_erase,
  output logic             rej_erase,
  output logic             susp_prg,
  output logic             susp_ers,
  output logic             res_prg,
  output logic             res_ers,
  output logic             clr_err
);

  logic running;
  logic is_prog, is_erase, is_susp, is_res;
  logic prog_legal, erase_legal;

  always_comb begin
    running  = (prg_act && !prg_susp) || (ers_act && !ers_susp);
    is_prog  = cmd_valid && (cmd == CMD_PROG);
    is_erase = cmd_valid && (cmd == CMD_ERASE);
    is_susp  = cmd_valid && (cmd == CMD_SUSP);
    is_res   = cmd_valid && (cmd == CMD_RESUME);

    prog_legal  = !running && !prg_act && !(ers_act && (blk == ers_blk));
    erase_legal = !ers_act && !prg_act;

    acc_prog  = is_prog && prog_legal;
    rej_prog  = is_prog && !prog_legal;
    acc_erase = is_erase && erase_legal;
    rej_erase = is_erase && !erase_legal;

    susp_prg  = is_susp && prg_act && !prg_susp;
    susp_ers  = is_susp && ers_act && !ers_susp && !prg_act;

    res_prg   = is_res && prg_susp;
    res_ers   = is_res && ers_susp && !prg_act;

    clr_err   = cmd_valid && (cmd == CMD_CLR);
  end

endmodule

// File: rtl/flash_susp_seq.sv
module flash_susp_seq
  import fss_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int PRG_CYC = 6,
  parameter int ERS_CYC = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic [BLK_W-1:0] rd_blk,
  output logic             busy,
  output logic             suspended,
  output logic [7:0]       status,
  output logic             read_mode,
  output logic             rd_allow
);

  localparam int CW = cnt_width(PRG_CYC, ERS_CYC);

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_code);

  logic             ers_act, ers_susp, prg_act, prg_susp;
  logic [BLK_W-1:0] ers_blk, prg_blk;
  logic             err_ers, err_prg, mode_stat;

  logic acc_prog, rej_prog, acc_erase, rej_erase;
  logic susp_prg, susp_ers, res_prg, res_ers, clr_err;

  logic [N_OPS-1:0] op_start, op_run, op_done;
  logic [CW-1:0]    op_rem [N_OPS];

  logic prg_running, ers_running, prg_done, ers_done;

  fss_cmd_check #(.BLK_W(BLK_W)) chk_i (
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .blk       (cmd_blk),
    .ers_act   (ers_act),
    .ers_susp  (ers_susp),
    .prg_act   (prg_act),
    .prg_susp  (prg_susp),
    .ers_blk   (ers_blk),
    .acc_prog  (acc_prog),
    .rej_prog  (rej_prog),
    .acc_erase (acc_erase),
    .rej_erase (rej_erase),
    .susp_prg  (susp_prg),
    .susp_ers  (susp_ers),
    .res_prg   (res_prg),
    .res_ers   (res_ers),
    .clr_err   (clr_err)
  );

  assign prg_running = prg_act && !prg_susp;
  assign ers_running = ers_act && !ers_susp && !prg_act;

  assign op_start[OP_PRG] = acc_prog;
  assign op_start[OP_ERS] = acc_erase;
  assign op_run[OP_PRG]   = prg_running && !susp_prg;
  assign op_run[OP_ERS]   = ers_running && !susp_ers;

  for (genvar g = 0; g < N_OPS; g++) begin : g_timer
    localparam int DUR = (g == OP_PRG) ? PRG_CYC : ERS_CYC;
    fss_op_timer #(.CW(CW), .DUR(DUR)) tmr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (op_start[g]),
      .run   (op_run[g]),
      .rem   (op_rem[g]),
      .done  (op_done[g])
    );
  end

  assign prg_done = op_done[OP_PRG];
  assign ers_done = op_done[OP_ERS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_act  <= 1'b0;
      prg_susp <= 1'b0;
      prg_blk  <= '0;
    end else begin
      if (acc_prog) begin
        prg_act <= 1'b1;
        prg_blk <= cmd_blk;
      end else if (prg_done) begin
        prg_act <= 1'b0;
      end
      if (susp_prg)     prg_susp <= 1'b1;
      else if (res_prg) prg_susp <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ers_act  <= 1'b0;
      ers_susp <= 1'b0;
      ers_blk  <= '0;
    end else begin
      if (acc_erase) begin
        ers_act <= 1'b1;
        ers_blk <= cmd_blk;
      end else if (ers_done) begin
        ers_act <= 1'b0;
      end
      if (susp_ers)     ers_susp <= 1'b1;
      else if (res_ers) ers_susp <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_ers <= 1'b0;
      err_prg <= 1'b0;
    end else if (clr_err) begin
      err_ers <= 1'b0;
      err_prg <= 1'b0;
    end else begin
      if (rej_erase) err_ers <= 1'b1;
      if (rej_prog)  err_prg <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_stat <= 1'b0;
    end else if (cmd_valid) begin
      if (cmd == CMD_RD_ARRAY)
        mode_stat <= 1'b0;
      else if (cmd == CMD_RD_STAT || cmd == CMD_RESUME)
        mode_stat <= 1'b1;
      else if (acc_prog || acc_erase || susp_prg || susp_ers)
        mode_stat <= 1'b1;
    end
  end

  assign busy      = prg_running || ers_running;
  assign suspended = prg_susp || ers_susp;
  assign status    = pack_status(!busy, ers_susp, err_ers, err_prg, prg_susp);
  assign read_mode = mode_stat;
  assign rd_allow  = !mode_stat && !busy
                     && !(ers_act && (rd_blk == ers_blk))
                     && !(prg_act && (rd_blk == prg_blk));

  AST_READ_SUSP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((ers_susp && rd_blk == ers_blk) || (prg_susp && rd_blk == prg_blk)) |-> !rd_allow);  // R1

  AST_ERASE_REJ_PSUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_ERASE && prg_susp) |=> (status[SR_EERR] && !busy));  // R2

  AST_PROG_IN_ESUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_PROG && ers_susp && !prg_act && cmd_blk != ers_blk) |=> busy);  // R3

  AST_NEST_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_susp && ers_susp) |-> (status[SR_READY] && status[SR_ESUSP] && status[SR_PSUSP]));  // R4

  AST_RESUME_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_RESUME) |=> read_mode);  // R5

  AST_RESUME_PRG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_RESUME && prg_susp && ers_susp)
      |=> (busy && status[SR_ESUSP] && !status[SR_PSUSP]));  // R7

  AST_IDLE_SUSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_SUSP && !busy) |=> $stable(status));  // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((status[SR_PERR] || status[SR_EERR]) && !(cmd_valid && cmd == CMD_CLR))
      |=> (status[SR_PERR] || status[SR_EERR]));  // R9

endmodule

// File: tb/flash_susp_seq_tb.sv
module flash_susp_seq_tb_top;

  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_code = 3'd0;
  logic [BW-1:0] cmd_blk = '0;
  logic [BW-1:0] rd_blk = '0;
  logic          busy, suspended, read_mode, rd_allow;
  logic [7:0]    status;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_susp_seq #(.BLK_W(BW), .PRG_CYC(4), .ERS_CYC(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_blk(cmd_blk), .rd_blk(rd_blk), .busy(busy), .suspended(suspended),
    .status(status), .read_mode(read_mode), .rd_allow(rd_allow)
  );

  typedef struct packed {
    logic [2:0] cmd;
    logic [3:0] blk;
    logic [7:0] st;
    logic       mode;
    logic       rd;
    logic [3:0] tag;
  } row_t;

  localparam int NROWS = 32;
  localparam row_t ROWS [NROWS] = '{
    '{3'd2, 4'd3,  8'h00, 1'b1, 1'b0, 4'd6},
    '{3'd0, 4'd0,  8'h00, 1'b1, 1'b0, 4'd6},
    '{3'd0, 4'd0,  8'h00, 1'b1, 1'b0, 4'd6},
    '{3'd3, 4'd0,  8'hC0, 1'b1, 1'b0, 4'd6},
    '{3'd6, 4'd3,  8'hC0, 1'b0, 1'b0, 4'd1},
    '{3'd1, 4'd3,  8'hD0, 1'b0, 1'b0, 4'd3},
    '{3'd5, 4'd2,  8'hC0, 1'b0, 1'b1, 4'd9},
    '{3'd1, 4'd5,  8'h40, 1'b1, 1'b0, 4'd3},
    '{3'd0, 4'd0,  8'h40, 1'b1, 1'b0, 4'd3},
    '{3'd3, 4'd0,  8'hC4, 1'b1, 1'b0, 4'd4},
    '{3'd6, 4'd5,  8'hC4, 1'b0, 1'b0, 4'd1},
    '{3'd0, 4'd3,  8'hC4, 1'b0, 1'b0, 4'd1},
    '{3'd0, 4'd1,  8'hC4, 1'b0, 1'b1, 4'd1},
    '{3'd2, 4'd7,  8'hE4, 1'b0, 1'b1, 4'd2},
    '{3'd1, 4'd6,  8'hF4, 1'b0, 1'b1, 4'd3},
    '{3'd0, 4'd2,  8'hF4, 1'b0, 1'b1, 4'd9},
    '{3'd5, 4'd0,  8'hC4, 1'b0, 1'b1, 4'd9},
    '{3'd4, 4'd9,  8'h40, 1'b1, 1'b0, 4'd7},
    '{3'd0, 4'd0,  8'h40, 1'b1, 1'b0, 4'd6},
    '{3'd4, 4'd0,  8'h40, 1'b1, 1'b0, 4'd7},
    '{3'd0, 4'd0,  8'hC0, 1'b1, 1'b0, 4'd7},
    '{3'd4, 4'd11, 8'h00, 1'b1, 1'b0, 4'd7},
    '{3'd0, 4'd0,  8'h00, 1'b1, 1'b0, 4'd6},
    '{3'd0, 4'd0,  8'h00, 1'b1, 1'b0, 4'd6},
    '{3'd0, 4'd0,  8'h00, 1'b1, 1'b0, 4'd6},
    '{3'd0, 4'd0,  8'h00, 1'b1, 1'b0, 4'd6},
    '{3'd0, 4'd0,  8'h00, 1'b1, 1'b0, 4'd6},
    '{3'd0, 4'd0,  8'h80, 1'b1, 1'b0, 4'd6},
    '{3'd3, 4'd0,  8'h80, 1'b1, 1'b0, 4'd8},
    '{3'd6, 4'd3,  8'h80, 1'b0, 1'b1, 4'd10},
    '{3'd7, 4'd0,  8'h80, 1'b1, 1'b0, 4'd10},
    '{3'd3, 4'd0,  8'h80, 1'b1, 1'b0, 4'd8}
  };

  function automatic string tag_s(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected busy/suspended follow from the status bit layout of R4
  task automatic expect_all(input string tag, input logic [7:0] st, input logic mode,
                            input logic rd);
    check(tag, "status", status, st);
    check(tag, "busy", {7'd0, busy}, {7'd0, !st[7]});
    check(tag, "suspended", {7'd0, suspended}, {7'd0, st[6] | st[2]});
    check(tag, "read_mode", {7'd0, read_mode}, {7'd0, mode});
    check(tag, "rd_allow", {7'd0, rd_allow}, {7'd0, rd});
  endtask

  task automatic step(input logic [2:0] c, input logic [3:0] b);
    @(negedge clk);
    cmd_valid = (c != 3'd0);
    cmd_code  = c;
    cmd_blk   = b;
    rd_blk    = b;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_code = 3'd0;
    rd_blk = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    expect_all("R10", 8'h80, 1'b0, 1'b1);  // R10 reset state

    for (int i = 0; i < NROWS; i++) begin
      step(ROWS[i].cmd, ROWS[i].blk);
      expect_all(tag_s(ROWS[i].tag), ROWS[i].st, ROWS[i].mode, ROWS[i].rd);
    end

    // R10: reset in the middle of an erase returns to the idle state
    step(3'd2, 4'd1);
    expect_all("R6", 8'h00, 1'b1, 1'b0);
    do_reset();
    expect_all("R10", 8'h80, 1'b0, 1'b1);

    // R2 / R3: commands rejected while an erase runs; error bits sticky (R9)
    step(3'd2, 4'd1);
    step(3'd2, 4'd2);
    expect_all("R2", 8'h20, 1'b1, 1'b0);
    step(3'd1, 4'd3);
    expect_all("R3", 8'h30, 1'b1, 1'b0);
    step(3'd0, 4'd0);
    expect_all("R9", 8'h30, 1'b1, 1'b0);
    do_reset();

    // R5: resume with nothing suspended still selects status mode
    step(3'd6, 4'd4);
    expect_all("R10", 8'h80, 1'b0, 1'b1);
    step(3'd4, 4'd15);
    expect_all("R5", 8'h80, 1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule